// File: doc/BRIEF.md
# Serial Frame Sequencer for a Crosspoint Control Port

This block runs on the host side of a video crosspoint switch whose control port is used in serial mode. The host hands it one 4-bit routing code at a time over a valid/ready handshake. For each code it produces four write strobes, and it presents the nibble on the serial data pin most significant bit first. It keeps count of which output the next code belongs to. After the eighth code of a frame it raises a latch pulse on its own, so that the switch copies its shift register into the active routing.

A latch can also be requested by hand at any moment. When that happens, the output count starts again from zero. The block keeps a mirror of the switch's 32-bit shift register, which is updated on every write rising edge, and a mirror of the image that the last latch made active. An incomplete frame, or a frame with an extra code, therefore shows up in the readback exactly as the switch would hold it, fields shifted and all. Strobe high and low widths are set in clock cycles, and each is never shorter than two cycles.

Top module: `xps_serial_seq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, code_ready is 1, xp_wr is 0, xp_latch_n is 1, xp_sdata is 0, out_index is 0, and both image outputs are all zero.
- R2: A code is taken on a clock edge where code_valid and code_ready are both 1. code_ready is 0 from the next cycle until the shift and any latch that follows it have finished. A code offered while code_ready is 0 is not taken.
- R3: Each code taken produces exactly four rising edges on xp_wr. On each rising edge, master_image shifts left by one bit and takes the xp_sdata value into bit 0.
- R4: xp_sdata carries the code bits in the order bit 3, bit 2, bit 1, bit 0. Each low phase of xp_wr lasts max(low_cycles,2) cycles and each high phase lasts max(high_cycles,2) cycles. xp_sdata changes only on the edge that starts a low phase, so it is stable at least one cycle before each rising edge and stays stable through the whole high phase.
- R5: out_index is 0 after reset and after every latch. It rises by one each time a code finishes without a latch following it.
- R6: When a code finishes with out_index at 7, xp_latch_n goes low on the next edge and stays low for max(low_cycles,2) cycles, then returns high.
- R7: On the rising edge of xp_latch_n, applied_image takes the value of master_image. A latch requested by hand while idle starts on the next edge and has the same shape, whether the frame is partial or complete.
- R8: A latch_req pulse seen during a shift (including in the same cycle the code is taken) is held back and served as a latch right after that code finishes. A latch_req seen while a latch is already running has no effect.
- R9: master_image behaves as one continuous 32-bit shift register that a latch does not clear. After a full frame, an extra code moves every output field one place toward the top, and the extra code lands in bits 3:0.
- R10: xp_wr is never 1 while xp_latch_n is 0, and xp_wr rests at 0 when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | Host offers a routing code |
| code_data | input | 4 | Routing code for the current output |
| code_ready | output | 1 | Sequencer idle and able to take a code |
| latch_req | input | 1 | One-cycle request for a manual latch pulse |
| low_cycles | input | 8 | Strobe low width and latch low width in clocks (minimum 2 applied) |
| high_cycles | input | 8 | Strobe high width in clocks (minimum 2 applied) |
| xp_wr | output | 1 | Write strobe; the switch shifts on its rising edge |
| xp_sdata | output | 1 | Serial data to the switch |
| xp_latch_n | output | 1 | Latch line, idles high, transfer on rising edge |
| out_index | output | 3 | Output the next code is meant for |
| master_image | output | 32 | Mirror of the switch shift register |
| applied_image | output | 32 | Mirror of the image made active by the last latch |

## Verification
The bench goes after the width clamp by programming widths of 0 and 1. A design without the clamp would produce one-cycle strobes that break setup. It also drives a manual latch in the middle of a shift, and another in the same cycle a code is taken. A design that served the request at once would cut a nibble in half, and one that dropped it would leave applied_image stale. A frame with one extra code checks that the mirror drifts by one field rather than restarting at output 0. A latch request arriving during a running latch checks that no second pulse is produced. The eighth-code boundary checks that the automatic latch comes exactly once and that out_index wraps to 0.

// File: rtl/xps_pkg.sv
package xps_pkg;

    localparam int NIB_W = 4;
    localparam int BIT_W = $clog2(NIB_W);

    typedef logic [NIB_W-1:0] nibble_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_BIT_LO,
        SEQ_BIT_HI,
        SEQ_LATCH
    } seq_state_e;

    typedef struct packed {
        logic wr;
        logic sdata;
        logic latch_n;
    } xp_pins_t;

    localparam xp_pins_t PINS_REST = '{wr: 1'b0, sdata: 1'b0, latch_n: 1'b1};

    // Bit of a nibble sent at position pos, top bit first.
    function automatic logic pick_bit(nibble_t nib, logic [BIT_W-1:0] pos);
        return nib[NIB_W - 1 - int'(pos)];
    endfunction

endpackage

// File: rtl/xps_phase_timer.sv
module xps_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] len_cfg,
    output logic             phase_last
);
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_eff;

    always_comb len_eff = (len_cfg < MIN_LEN) ? MIN_LEN : len_cfg;
    always_comb phase_last = (cnt_q == (len_eff - ONE));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/xps_frame_ctrl.sv
module xps_frame_ctrl
    import xps_pkg::*;
#(
    parameter int NUM_OUT = 8,
    localparam int IDX_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             code_valid,
    input  nibble_t          code_data,
    input  logic             latch_req,
    input  logic             phase_last,
    output logic             code_ready,
    output logic             timer_restart,
    output logic             use_high,
    output logic             shift_en,
    output logic             commit,
    output xp_pins_t         pins,
    output logic [IDX_W-1:0] out_idx
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NIB_W - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_OUT - 1);

    seq_state_e       state_q;
    xp_pins_t         pins_q;
    nibble_t          nib_q;
    logic [BIT_W-1:0] bit_q;
    logic [IDX_W-1:0] idx_q;
    logic             pend_q;
    logic             take;
    logic             frame_full;
    logic             want_latch;

    always_comb begin
        code_ready    = (state_q == SEQ_IDLE);
        take          = code_ready && code_valid;
        frame_full    = (idx_q == IDX_LAST);
        want_latch    = frame_full || pend_q || latch_req;
        timer_restart = (state_q == SEQ_IDLE) || phase_last;
        use_high      = (state_q == SEQ_BIT_HI);
        shift_en      = (state_q == SEQ_BIT_LO) && phase_last;
        commit        = (state_q == SEQ_LATCH) && phase_last;
        pins          = pins_q;
        out_idx       = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pins_q  <= PINS_REST;
            nib_q   <= '0;
            bit_q   <= '0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (take) begin
                        nib_q        <= code_data;
                        bit_q        <= '0;
                        pins_q.sdata <= pick_bit(code_data, '0);
                        pend_q       <= latch_req;
                        state_q      <= SEQ_BIT_LO;
                    end else if (latch_req) begin
                        pins_q.latch_n <= 1'b0;
                        state_q        <= SEQ_LATCH;
                    end
                end
                SEQ_BIT_LO: begin
                    if (latch_req) pend_q <= 1'b1;
                    if (phase_last) begin
                        pins_q.wr <= 1'b1;
                        state_q   <= SEQ_BIT_HI;
                    end
                end
                SEQ_BIT_HI: begin
                    if (latch_req) pend_q <= 1'b1;
                    if (phase_last) begin
                        pins_q.wr <= 1'b0;
                        if (bit_q == BIT_LAST) begin
                            if (want_latch) begin
                                pins_q.latch_n <= 1'b0;
                                state_q        <= SEQ_LATCH;
                            end else begin
                                idx_q   <= idx_q + IDX_W'(1);
                                state_q <= SEQ_IDLE;
                            end
                        end else begin
                            bit_q        <= bit_q + BIT_W'(1);
                            pins_q.sdata <= pick_bit(nib_q, bit_q + BIT_W'(1));
                            state_q      <= SEQ_BIT_LO;
                        end
                    end
                end
                SEQ_LATCH: begin
                    if (phase_last) begin
                        pins_q.latch_n <= 1'b1;
                        idx_q          <= '0;
                        pend_q         <= 1'b0;
                        state_q        <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assert_wr_latch_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(pins_q.wr && !pins_q.latch_n));

    assert_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.wr) |-> $stable(pins_q.sdata));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.wr) |=> (pins_q.wr && $stable(pins_q.sdata)));

    assert_low_min_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.wr) |=> !pins_q.wr);

    assert_latch_min_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.latch_n) |=> !pins_q.latch_n);

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code_ready) |=> !code_ready);

endmodule

// File: rtl/xps_shadow_regs.sv
module xps_shadow_regs
    import xps_pkg::*;
#(
    parameter int NUM_OUT = 8,
    localparam int FRAME_W = NUM_OUT * NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               shift_bit,
    input  logic               commit,
    output logic [FRAME_W-1:0] master,
    output logic [FRAME_W-1:0] applied
);
    logic [FRAME_W-1:0] master_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= '0;
        end else if (shift_en) begin
            master_q <= {master_q[FRAME_W-2:0], shift_bit};
        end
    end

    // One routing field per output, copied together on a latch.
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_field
        nibble_t field_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                field_q <= '0;
            end else if (commit) begin
                field_q <= master_q[g*NIB_W +: NIB_W];
            end
        end
        assign applied[g*NIB_W +: NIB_W] = field_q;
    end

    assign master = master_q;
endmodule

// File: rtl/xps_serial_seq.sv
module xps_serial_seq
    import xps_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
    localparam int FRAME_W = NUM_OUT * NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               code_valid,
    input  logic [NIB_W-1:0]   code_data,
    output logic               code_ready,
    input  logic               latch_req,
    input  logic [CNT_W-1:0]   low_cycles,
    input  logic [CNT_W-1:0]   high_cycles,
    output logic               xp_wr,
    output logic               xp_sdata,
    output logic               xp_latch_n,
    output logic [IDX_W-1:0]   out_index,
    output logic [FRAME_W-1:0] master_image,
    output logic [FRAME_W-1:0] applied_image
);
    logic             phase_last;
    logic             timer_restart;
    logic             use_high;
    logic             shift_en;
    logic             commit;
    xp_pins_t         pins;
    logic [CNT_W-1:0] len_sel;

    always_comb len_sel = use_high ? high_cycles : low_cycles;

    xps_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .restart    (timer_restart),
        .len_cfg    (len_sel),
        .phase_last (phase_last)
    );

    xps_frame_ctrl #(.NUM_OUT(NUM_OUT)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .code_valid    (code_valid),
        .code_data     (code_data),
        .latch_req     (latch_req),
        .phase_last    (phase_last),
        .code_ready    (code_ready),
        .timer_restart (timer_restart),
        .use_high      (use_high),
        .shift_en      (shift_en),
        .commit        (commit),
        .pins          (pins),
        .out_idx       (out_index)
    );

    xps_shadow_regs #(.NUM_OUT(NUM_OUT)) shadow_i (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .shift_bit (pins.sdata),
        .commit    (commit),
        .master    (master_image),
        .applied   (applied_image)
    );

    assign xp_wr      = pins.wr;
    assign xp_sdata   = pins.sdata;
    assign xp_latch_n = pins.latch_n;

    assert_commit_image_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(xp_latch_n) |-> (applied_image == master_image));

    assert_frozen_in_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (!xp_latch_n && $past(!xp_latch_n)) |-> $stable(master_image));

endmodule

// File: tb/xps_serial_seq_tb_top.sv
module xps_serial_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_valid = 1'b0;
    logic [3:0]  code_data = '0;
    logic        code_ready;
    logic        latch_req = 1'b0;
    logic [7:0]  low_cycles = 8'd2;
    logic [7:0]  high_cycles = 8'd2;
    logic        xp_wr, xp_sdata, xp_latch_n;
    logic [2:0]  out_index;
    logic [31:0] master_image, applied_image;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit started = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xps_serial_seq dut_i (
        .clk(clk), .rst(rst), .code_valid(code_valid), .code_data(code_data),
        .code_ready(code_ready), .latch_req(latch_req), .low_cycles(low_cycles),
        .high_cycles(high_cycles), .xp_wr(xp_wr), .xp_sdata(xp_sdata),
        .xp_latch_n(xp_latch_n), .out_index(out_index),
        .master_image(master_image), .applied_image(applied_image)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    // Entries: {latch_n, wr, sdata} for each future cycle.
    bit [2:0]  m_q[$];
    bit [2:0]  m_cur = 3'b100;
    bit [2:0]  m_prev;
    bit        m_active = 1'b0;
    bit        m_is_latch = 1'b0;
    bit        m_pend = 1'b0;
    int        m_idx = 0;
    bit [31:0] m_master = '0;
    bit [31:0] m_applied = '0;

    function automatic int eff(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic push_code(input bit [3:0] nib);
        for (int b = 3; b >= 0; b--) begin
            repeat (eff(int'(low_cycles)))  m_q.push_back({1'b1, 1'b0, nib[b]});
            repeat (eff(int'(high_cycles))) m_q.push_back({1'b1, 1'b1, nib[b]});
        end
    endtask

    task automatic push_latch();
        repeat (eff(int'(low_cycles))) m_q.push_back({1'b0, 1'b0, m_cur[0]});
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_cur = 3'b100; m_active = 0; m_is_latch = 0; m_pend = 0;
            m_idx = 0; m_master = '0; m_applied = '0;
        end else begin
            m_prev = m_cur;
            if (m_active && !m_is_latch && latch_req) m_pend = 1;
            if (!m_active) begin
                if (code_valid) begin
                    push_code(code_data); m_pend = latch_req; m_is_latch = 0;
                end else if (latch_req) begin
                    push_latch(); m_is_latch = 1;
                end
            end
            if (m_q.size() != 0) begin
                m_cur = m_q.pop_front(); m_active = 1;
            end else if (m_active) begin
                if (!m_is_latch) begin
                    if (m_idx == 7 || m_pend) begin
                        push_latch(); m_cur = m_q.pop_front(); m_is_latch = 1;
                    end else begin
                        m_idx++; m_cur = {1'b1, 1'b0, m_cur[0]}; m_active = 0;
                    end
                end else begin
                    m_cur = {1'b1, 1'b0, m_cur[0]};
                    m_applied = m_master; m_idx = 0; m_pend = 0; m_active = 0;
                end
            end
            if (m_cur[1] && !m_prev[1]) m_master = {m_master[30:0], m_cur[0]};
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        cyc++;
        if (started && !rst) begin
            chk("R2 code_ready", code_ready, !m_active);
            chk("R3 xp_wr", xp_wr, m_cur[1]);
            chk("R4 xp_sdata", xp_sdata, m_cur[0]);
            chk("R6 xp_latch_n", xp_latch_n, m_cur[2]);
            chk("R5 out_index", out_index, m_idx);
            chk("R9 master_image", master_image, m_master);
            chk("R7 applied_image", applied_image, m_applied);
            chk("R10 wr during latch", xp_wr & ~xp_latch_n, 1'b0);
        end
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input bit [3:0] nib, input bit with_latch);
        code_valid = 1'b1; code_data = nib; latch_req = with_latch;
        while (!code_ready) @(negedge clk);
        @(negedge clk);
        code_valid = 1'b0; latch_req = 1'b0;
    endtask

    task automatic pulse_latch();
        latch_req = 1'b1;
        @(negedge clk);
        latch_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (!code_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 ready", code_ready, 1'b1);
        chk("R1 wr", xp_wr, 1'b0);
        chk("R1 latch_n", xp_latch_n, 1'b1);
        chk("R1 sdata", xp_sdata, 1'b0);
        chk("R1 index", out_index, 3'd0);
        chk("R1 master", master_image, 32'h0);
        chk("R1 applied", applied_image, 32'h0);
        started = 1'b1;

        // R4 clamp: widths 0 and 1 behave as 2; R7 partial frame by hand
        low_cycles = 8'd0; high_cycles = 8'd1;
        send(4'h9, 0); send(4'h0, 0); send(4'h9, 0);
        wait_idle();
        chk("R5 index after three codes", out_index, 3'd3);
        pulse_latch();
        wait_idle();
        chk("R7 partial frame applied", applied_image, 32'h0000_0909);
        chk("R5 index after manual latch", out_index, 3'd0);

        // R6 full frame with wider phases, auto latch
        low_cycles = 8'd3; high_cycles = 8'd4;
        for (int k = 1; k <= 8; k++) send(4'(k), 0);
        wait_idle();
        chk("R6 auto latch applied", applied_image, 32'h1234_5678);
        chk("R6 index wrapped", out_index, 3'd0);

        // R9 extra code then manual latch: fields drift by one place
        low_cycles = 8'd2; high_cycles = 8'd2;
        send(4'hA, 0);
        wait_idle();
        chk("R3 master after extra code", master_image, 32'h2345_678A);
        pulse_latch();
        wait_idle();
        chk("R9 drifted image", applied_image, 32'h2345_678A);

        // R8 request during a shift is queued
        send(4'h5, 0);
        repeat (3) @(negedge clk);
        pulse_latch();
        wait_idle();
        chk("R8 queued latch applied", applied_image, 32'h3456_78A5);
        chk("R8 index after queued latch", out_index, 3'd0);

        // R8 request in the same cycle as the code
        send(4'h6, 1);
        wait_idle();
        chk("R8 same-cycle latch applied", applied_image, 32'h4567_8A56);

        // R8 second request during a running latch has no effect
        pulse_latch();
        pulse_latch();
        wait_idle();
        chk("R8 ready after single latch", code_ready, 1'b1);
        chk("R7 applied unchanged by empty latch", applied_image, 32'h4567_8A56);

        // R5 and R6 again with a long low width
        low_cycles = 8'd5;
        for (int k = 0; k < 8; k++) send(4'hF - 4'(k), 0);
        wait_idle();
        chk("R6 second frame applied", applied_image, 32'hFEDC_BA98);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule